// File: doc/BRIEF.md
# Mitchell Logarithmic Multiply/Divide Unit

This unit returns an approximate product or quotient of two unsigned integers without a multiplier array or a divider. Each operand passes through a leading-one detector. The detector gives the position `k` of the highest set bit and the bits below that bit, left-aligned as a fraction `x`. The operand is then treated as `2^k·(1+x)`, and its base-2 logarithm is taken to be `k + x`.

A multiply adds the two logarithms and a divide subtracts them. The result is turned back into an integer by a barrel shift of the mantissa `1.f`. The carry or borrow out of the fraction adder picks both the mantissa bits and a one-step change of the exponent. Zero operands bypass the datapath: a zero factor gives zero, and a zero divisor gives a saturated quotient together with an error flag.

The unit takes one request per cycle. It has a single register stage at the output, so a result appears in the cycle after its request strobe. It fits datapaths where a product error of a few percent is acceptable in exchange for area and power.

Top module: `mlog_muldiv`

## Requirements
- R1: `res_vld_o` is high in exactly those cycles that follow a cycle with `req_vld_i` high, and is 0 in every other cycle.
- R2: With `op_i`=0 (multiply) and both operands nonzero, let s = fa + fb be summed with FW = W−1 fraction bits, and let c be its carry. Form the mantissa m = {1, s[FW−1:0]} and the exponent e = ka + kb + c. The result is (m·2^e) >> FW, truncated, on 2W bits.
- R3: A multiply of two powers of two is exact. A multiply by 1 returns the other operand unchanged.
- R4: A multiply with either operand zero returns 0, and `err_o` stays 0.
- R5: With `op_i`=1 (divide) and both operands nonzero, let d = fa − fb and let b be its borrow. Form the mantissa m = {1, d[FW−1:0]} and the exponent e = ka − kb − b. The quotient is m >> (FW − e), truncated. It sits in the low W bits of `res_o`, and the upper W bits are 0.
- R6: Dividing by 1 returns the dividend, and dividing a nonzero operand by itself returns 1.
- R7: A divide with `b_i`=0 returns all ones in the low W bits and zeros above them, and raises `err_o`. `err_o` is never high without `res_vld_o`.
- R8: A divide with `a_i`=0 and `b_i`≠0 returns 0, and `err_o` stays 0.
- R9: In a cycle without a request, `res_o` keeps its previous value whatever the operands do.
- R10: After reset, `res_o`, `res_vld_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Request strobe |
| op_i | input | 1 | Operation: 0 multiply, 1 divide |
| a_i | input | W | First operand (dividend) |
| b_i | input | W | Second operand (divisor) |
| res_vld_o | output | 1 | Result valid, one cycle after the request |
| res_o | output | 2W | Product, or quotient in the low W bits |
| err_o | output | 1 | Divide by zero |

## Verification
Random operand pairs in both modes cover the carry and no-carry paths of the fraction sum and the borrow and no-borrow paths of the fraction difference. Any mistake in mantissa selection or in the exponent adjustment changes the value compared against the bench model. Powers of two, unit operands and self-division have exact answers, so they separate a correct leading-one and fraction extraction from one that is off by a bit. Zero operands in each position, and all-ones operands, test the bypass paths and the widest shifts. Idle cycles with changing operands show that the output register does not capture them.

// File: rtl/mlog_pkg.sv
package mlog_pkg;
    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } mlog_op_e;
endpackage

// File: rtl/mlog_lod.sv
module mlog_lod #(
    parameter int W  = 8,
    localparam int KW = $clog2(W),
    localparam int FW = W - 1
) (
    input  logic [W-1:0]  val_i,
    output logic [KW-1:0] k_o,
    output logic [FW-1:0] frac_o,
    output logic          zero_o
);
    logic [W-1:0] aligned;

    always_comb begin
        k_o = '0;
        for (int i = 0; i < W; i++) begin
            if (val_i[i]) k_o = KW'(i);
        end
    end

    // shift the leading one up to the top bit; the bits beneath it are the fraction
    assign aligned = val_i << (KW'(FW) - k_o);
    assign frac_o  = aligned[FW-1:0];
    assign zero_o  = (val_i == '0);
endmodule

// File: rtl/mlog_antilog.sv
module mlog_antilog #(
    parameter int W  = 8,
    localparam int KW = $clog2(W),
    localparam int FW = W - 1,
    localparam int PW = 2 * W
) (
    input  logic [W-1:0]  mant_i,
    input  logic [KW:0]   exp_up_i,
    input  logic [KW:0]   sh_down_i,
    input  logic          is_div_i,
    output logic [PW-1:0] res_o
);
    logic [PW+FW-1:0] wide;
    logic [W-1:0]     quo;

    assign wide = (PW+FW)'(mant_i) << exp_up_i;
    assign quo  = mant_i >> sh_down_i;

    always_comb begin
        if (is_div_i) res_o = {{W{1'b0}}, quo};
        else          res_o = wide[FW +: PW];
    end
endmodule

// File: rtl/mlog_muldiv.sv
module mlog_muldiv
    import mlog_pkg::*;
#(
    parameter int W  = 8,
    localparam int KW = $clog2(W),
    localparam int FW = W - 1,
    localparam int PW = 2 * W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_vld_i,
    input  logic          op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic          res_vld_o,
    output logic [PW-1:0] res_o,
    output logic          err_o
);
    mlog_op_e      op;
    logic [KW-1:0] ka, kb;
    logic [FW-1:0] fa, fb;
    logic          za, zb;
    logic [FW:0]   fsum, fdif;
    logic          cy, bw;
    logic [W-1:0]  mant;
    logic [KW:0]   exp_up, sh_down;
    logic [PW-1:0] shifted;
    logic [PW-1:0] res_d;
    logic          err_d;

    assign op = mlog_op_e'(op_i);

    mlog_lod #(.W(W)) lod_a_i (.val_i(a_i), .k_o(ka), .frac_o(fa), .zero_o(za));
    mlog_lod #(.W(W)) lod_b_i (.val_i(b_i), .k_o(kb), .frac_o(fb), .zero_o(zb));

    // fraction add / subtract; the carry or borrow steers the mantissa and exponent
    assign fsum = {1'b0, fa} + {1'b0, fb};
    assign fdif = {1'b0, fa} - {1'b0, fb};
    assign cy   = fsum[FW];
    assign bw   = fdif[FW];

    always_comb begin
        if (op == OP_DIV) mant = {1'b1, fdif[FW-1:0]};
        else              mant = {1'b1, fsum[FW-1:0]};
    end

    assign exp_up  = (KW+1)'(ka) + (KW+1)'(kb) + (KW+1)'(cy);
    assign sh_down = (KW+1)'(FW) - (KW+1)'(ka) + (KW+1)'(kb) + (KW+1)'(bw);

    mlog_antilog #(.W(W)) alog_i (
        .mant_i   (mant),
        .exp_up_i (exp_up),
        .sh_down_i(sh_down),
        .is_div_i (op == OP_DIV),
        .res_o    (shifted)
    );

    always_comb begin
        res_d = shifted;
        err_d = 1'b0;
        unique case (op)
            OP_MUL: if (za || zb) res_d = '0;
            OP_DIV: begin
                if (zb) begin
                    res_d = {{W{1'b0}}, {W{1'b1}}};
                    err_d = 1'b1;
                end else if (za) begin
                    res_d = '0;
                end
            end
            default: res_d = shifted;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_vld_o <= 1'b0;
            res_o     <= '0;
            err_o     <= 1'b0;
        end else begin
            res_vld_o <= req_vld_i;
            err_o     <= req_vld_i && err_d;
            if (req_vld_i) res_o <= res_d;
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_vld_i |=> res_vld_o);
    p_no_spurious_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_vld_i |=> !res_vld_o);
    p_pow2_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && op_i == 1'b0 && $onehot(a_i) && $onehot(b_i))
        |=> res_o == $past(PW'(a_i) * PW'(b_i)));
    p_mul_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && op_i == 1'b0 && (a_i == '0 || b_i == '0))
        |=> (res_o == '0 && !err_o));
    p_div_self_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && op_i == 1'b1 && a_i == b_i && a_i != '0)
        |=> res_o == PW'(1));
    p_div_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && op_i == 1'b1 && b_i == '0)
        |=> (err_o && res_o == {{W{1'b0}}, {W{1'b1}}}));
    p_err_with_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> res_vld_o);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_vld_i |=> $stable(res_o));
endmodule

// File: tb/mlog_muldiv_tb_top.sv
module mlog_muldiv_tb_top;
    localparam int W  = 8;
    localparam int FW = W - 1;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          req_vld_i = 1'b0;
    logic          op_i = 1'b0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic          res_vld_o;
    logic [PW-1:0] res_o;
    logic          err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mlog_muldiv #(.W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .req_vld_i(req_vld_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .res_vld_o(res_vld_o), .res_o(res_o), .err_o(err_o)
    );

    function automatic int lead(longint v);
        int k = 0;
        for (int i = 0; i < W; i++) if (v[i]) k = i;
        return k;
    endfunction

    function automatic longint model(longint a, longint b, bit dv);
        int ka, kb, e;
        longint fa, fb, s, m, msk;
        msk = (64'd1 << FW) - 1;
        if (!dv && (a == 0 || b == 0)) return 0;
        if (dv && b == 0) return (64'd1 << W) - 1;
        if (dv && a == 0) return 0;
        ka = lead(a); kb = lead(b);
        fa = (a - (64'd1 << ka)) << (FW - ka);
        fb = (b - (64'd1 << kb)) << (FW - kb);
        if (!dv) begin
            s = fa + fb;
            m = (64'd1 << FW) | (s & msk);
            e = ka + kb + int'(s >> FW);
            return (m << e) >> FW;
        end
        if (fa >= fb) begin
            m = (64'd1 << FW) | (fa - fb);
            e = ka - kb;
        end else begin
            m = (64'd1 << (FW + 1)) + fa - fb;
            e = ka - kb - 1;
        end
        return m >> (FW - e);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic run(string req, logic [W-1:0] a, logic [W-1:0] b, bit dv);
        longint exp;
        @(negedge clk);
        a_i = a; b_i = b; op_i = dv; req_vld_i = 1'b1;
        exp = model(longint'(a), longint'(b), dv);
        @(negedge clk);
        req_vld_i = 1'b0;
        check({req, " valid"}, longint'(res_vld_o), 1);
        check({req, " result"}, longint'(res_o), exp);
        check({req, " err"}, longint'(err_o), (dv && b == 0) ? 1 : 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [PW-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 valid", longint'(res_vld_o), 0);
        check("R10 result", longint'(res_o), 0);
        check("R10 err", longint'(err_o), 0);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1 idle valid", longint'(res_vld_o), 0);

        // R3 exact cases
        run("R3 pow2", 8'd16, 8'd8, 1'b0);
        check("R3 pow2 exact", longint'(res_o), 128);
        run("R3 by one", 8'd201, 8'd1, 1'b0);
        check("R3 by one exact", longint'(res_o), 201);
        run("R3 one by", 8'd1, 8'd77, 1'b0);
        check("R3 one by exact", longint'(res_o), 77);
        // R4 zero factors
        run("R4 a zero", 8'd0, 8'd99, 1'b0);
        run("R4 b zero", 8'd250, 8'd0, 1'b0);
        check("R4 value", longint'(res_o), 0);
        // R2 widest
        run("R2 max", 8'd255, 8'd255, 1'b0);
        check("R2 max value", longint'(res_o), 65024);
        // R6 exact divides
        run("R6 div one", 8'd173, 8'd1, 1'b1);
        check("R6 div one exact", longint'(res_o), 173);
        run("R6 self", 8'd93, 8'd93, 1'b1);
        check("R6 self exact", longint'(res_o), 1);
        // R7 divide by zero
        run("R7 div zero", 8'd200, 8'd0, 1'b1);
        check("R7 value", longint'(res_o), 255);
        check("R7 err", longint'(err_o), 1);
        // R8 zero dividend
        run("R8 zero num", 8'd0, 8'd5, 1'b1);
        check("R8 value", longint'(res_o), 0);
        // R5 small quotient
        run("R5 tiny", 8'd1, 8'd255, 1'b1);
        run("R5 borrow", 8'd130, 8'd7, 1'b1);

        // R9 hold on idle cycles with moving inputs
        held = res_o;
        @(negedge clk);
        a_i = 8'd3; b_i = 8'd0; op_i = 1'b1;
        @(negedge clk);
        check("R9 hold", longint'(res_o), longint'(held));
        check("R1 no strobe", longint'(res_vld_o), 0);
        check("R7 no err idle", longint'(err_o), 0);

        // R2 / R5 random
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] ra, rb;
            bit dv;
            ra = W'($urandom);
            rb = W'($urandom);
            dv = 1'($urandom);
            if (dv) run("R5 rand", ra, rb, 1'b1);
            else    run("R2 rand", ra, rb, 1'b0);
        end

        // R1 back-to-back strobes
        @(negedge clk);
        a_i = 8'd12; b_i = 8'd10; op_i = 1'b0; req_vld_i = 1'b1;
        @(negedge clk);
        check("R1 b2b first", longint'(res_vld_o), 1);
        check("R2 b2b first", longint'(res_o), model(12, 10, 1'b0));
        a_i = 8'd100; b_i = 8'd9; op_i = 1'b1;
        @(negedge clk);
        req_vld_i = 1'b0;
        check("R1 b2b second", longint'(res_vld_o), 1);
        check("R5 b2b second", longint'(res_o), model(100, 9, 1'b1));
        @(negedge clk);
        check("R1 after b2b", longint'(res_vld_o), 0);

        done = 1'b1;
        summary();
    end
endmodule